// File: doc/BRIEF.md
# CPU Bus Transfer Classifier and Terminator

This block sits on the processor side of a host bridge and works out what every bus transaction is at the cycle its transfer start is seen. It looks at the 4-bit transfer type, the transfer size code, the burst flag, the address and a programmable top-of-memory value. It then sorts the transaction into one of five kinds: address-only, special (external control in/out), illegal size or alignment, memory access above top-of-memory, or a memory access that is handed to a downstream target. It produces the address-acknowledge, transfer-acknowledge and transfer-error-acknowledge strobes that close the transaction, and a drive-all-ones enable for the data bus where one is required.

The DRAM, PCI and ROM back ends are reduced to a request level plus a done/error pulse pair. Only one transaction is handled at a time, and address acknowledge always falls in the same cycle as the last data beat. Two sticky error flags, one for size faults and one for target faults, hold the failing address of the first error until software pulses the clear input.

Transfer type encoding: `tt_i[3]` is the special-operation bit, `tt_i[2]` the read bit, `tt_i[1]` the cache-invalidate bit and `tt_i[0]` the data-phase bit. The value of `tt_i` is written below as a 4-bit binary code with `tt_i[3]` first.

Top module: `cbt_term`

## Requirements
- R1: Any code whose data-phase bit `tt_i[0]` is 0, other than 1010b and 1110b, ends one cycle after transfer start with `aack_o` alone for one cycle. There is no `ta_o`, no `tea_o`, no target request and no error flag, whatever the size and address.
- R2: Codes 1010b and 1110b end one cycle after transfer start with `aack_o` and `ta_o` together for one cycle and no error. For 1110b only, `ones_o` is high in that cycle.
- R3: For a data transfer, `tt_i[2]`=1 is a read and 0 is a write. A read to the target shows `tgt_rd_o`=1 while `tgt_req_o` is high.
- R4: Size legality without burst: `tsiz_i` 001/010/011/100 mean 1 to 4 bytes and must not cross the 8-byte boundary (`addr_i[2:0]` plus size at most 8); 000 means 8 bytes and needs `addr_i[2:0]`=0; 101, 110 and 111 are always illegal. An illegal transfer ends one cycle after transfer start with `aack_o` and `tea_o` for one cycle, and `size_err_o` is set from the following cycle.
- R5: With `burst_i`=1 the transfer is 32 bytes in four 8-byte beats and needs `addr_i[2:0]`=0. Otherwise any size is an error as in R4. A legal burst gives `ta_o` in four consecutive cycles, and a single transfer gives it in one.
- R6: A legal data transfer with `addr_i` >= `tom_i` makes no target request. Its beats start one cycle after transfer start, with no error, and a read drives `ones_o` on every beat.
- R7: A legal data transfer below `tom_i` raises `tgt_req_o` one cycle after transfer start and holds it until `tgt_done_i` or `tgt_err_i` is sampled. After done, the beats start the next cycle. After error (error wins over done), `aack_o` and `tea_o` come the next cycle and `tgt_err_o` is set from the cycle after.
- R8: No pipelining. `aack_o` is high only together with the last `ta_o` (or with `tea_o`, or alone for R1). Transfer start is ignored while a transaction is in progress, and the cycle after `aack_o` is idle.
- R9: `size_err_o` and `tgt_err_o` stay set until `err_clr_i` is pulsed. `err_addr_o` takes the transaction address only on an error that finds both flags clear, or that coincides with a clear.
- R10: After reset all strobes, the request and both flags are 0 and `err_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_i | input | 1 | Transfer start, one cycle |
| tt_i | input | 4 | Transfer type code |
| tsiz_i | input | 3 | Transfer size code |
| burst_i | input | 1 | Burst transfer, active high |
| addr_i | input | AW | Transaction address |
| tom_i | input | AW | Top-of-memory limit |
| tgt_done_i | input | 1 | Downstream target finished |
| tgt_err_i | input | 1 | Downstream target failed |
| err_clr_i | input | 1 | Clear the sticky error flags |
| aack_o | output | 1 | Address acknowledge |
| ta_o | output | 1 | Transfer acknowledge (one per beat) |
| tea_o | output | 1 | Transfer error acknowledge |
| ones_o | output | 1 | Drive all ones on the data bus |
| tgt_req_o | output | 1 | Request to the downstream target |
| tgt_rd_o | output | 1 | Target request is a read |
| size_err_o | output | 1 | Sticky size/alignment error flag |
| tgt_err_o | output | 1 | Sticky target error flag |
| err_addr_o | output | AW | Address of the first unacknowledged error |

## Verification
All sixteen transfer-type codes are sent both single-beat and burst. This separates the address-only, special and data paths, and the ones drive of 1110b from that of 1010b. All 8 size codes are crossed with all 8 low address offsets, for single and burst transfers, reads and writes, with varied target latency. This sweep separates legal from illegal size and alignment combinations, and one-beat from four-beat terminations. Addresses just below and exactly at top-of-memory separate the target path from the unmapped path, and reads from writes there. Target errors, a size error on top of a held flag, clearing, and a transfer start poked mid-transaction cover stickiness, first-error address capture and the absence of pipelining.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    // Bit positions inside the 4-bit transfer type code (MSB = special bit)
    localparam int TT_READ_BIT = 2;
    localparam int TT_DATA_BIT = 0;

    localparam logic [3:0] TT_EXT_OUT = 4'b1010;
    localparam logic [3:0] TT_EXT_IN  = 4'b1110;

    typedef enum logic [2:0] {
        K_ADDR_ONLY,
        K_SPECIAL,
        K_SIZE_ERR,
        K_HOLE,
        K_MEMORY
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_BEAT,
        S_ACK,
        S_FAIL
    } state_e;

    typedef struct packed {
        kind_e kind;
        logic  rd;
        logic  burst;
        logic  ones;
    } dec_t;

    // Legal size / low-address combination for a data transfer
    function automatic logic size_legal(input logic       burst,
                                        input logic [2:0] tsiz,
                                        input logic [2:0] ofs);
        logic [3:0] span;
        logic       ok;
        span = {1'b0, ofs} + {1'b0, tsiz};
        if (burst) begin
            ok = (ofs == 3'd0);
        end else begin
            case (tsiz)
                3'd0:                   ok = (ofs == 3'd0);
                3'd1, 3'd2, 3'd3, 3'd4: ok = (span <= 4'd8);
                default:                ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/cbt_decode.sv
module cbt_decode
    import cbt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [3:0]    tt_i,
    input  logic [2:0]    tsiz_i,
    input  logic          burst_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] tom_i,
    output dec_t          dec_o
);

    logic special;
    logic has_data;
    logic legal;
    logic above;

    always_comb begin
        special  = (tt_i == TT_EXT_OUT) || (tt_i == TT_EXT_IN);
        has_data = tt_i[TT_DATA_BIT];
        legal    = size_legal(burst_i, tsiz_i, addr_i[2:0]);
        above    = (addr_i >= tom_i);

        dec_o       = '0;
        dec_o.rd    = tt_i[TT_READ_BIT];
        dec_o.burst = burst_i;
        if (special) begin
            dec_o.kind = K_SPECIAL;
            dec_o.ones = (tt_i == TT_EXT_IN);
        end else if (!has_data) begin
            dec_o.kind = K_ADDR_ONLY;
        end else if (!legal) begin
            dec_o.kind = K_SIZE_ERR;
        end else if (above) begin
            dec_o.kind = K_HOLE;
            dec_o.ones = tt_i[TT_READ_BIT];
        end else begin
            dec_o.kind = K_MEMORY;
        end
    end

endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
    import cbt_pkg::*;
#(
    parameter int AW          = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ts_i,
    input  dec_t          dec_i,
    input  logic [AW-1:0] addr_i,
    input  logic          tgt_done_i,
    input  logic          tgt_err_i,
    output logic          aack_o,
    output logic          ta_o,
    output logic          tea_o,
    output logic          ones_o,
    output logic          tgt_req_o,
    output logic          tgt_rd_o,
    output logic          fail_ev_o,
    output logic          fail_size_o,
    output logic [AW-1:0] fail_addr_o
);

    localparam int             CW       = (BURST_BEATS > 2) ? $clog2(BURST_BEATS) : 1;
    localparam logic [CW-1:0]  LAST_CNT = CW'(BURST_BEATS - 1);

    state_e        st;
    logic [CW-1:0] cnt;
    logic          r_rd;
    logic          r_ones;
    logic          r_ta;
    logic          r_size;
    logic [AW-1:0] r_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            r_rd   <= 1'b0;
            r_ones <= 1'b0;
            r_ta   <= 1'b0;
            r_size <= 1'b0;
            r_addr <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (ts_i) begin
                        r_addr <= addr_i;
                        r_rd   <= dec_i.rd;
                        r_ones <= dec_i.ones;
                        r_ta   <= 1'b0;
                        cnt    <= dec_i.burst ? LAST_CNT : '0;
                        case (dec_i.kind)
                            K_ADDR_ONLY: st <= S_ACK;
                            K_SPECIAL: begin
                                st   <= S_ACK;
                                r_ta <= 1'b1;
                            end
                            K_SIZE_ERR: begin
                                st     <= S_FAIL;
                                r_size <= 1'b1;
                            end
                            K_HOLE:  st <= S_BEAT;
                            default: st <= S_WAIT;
                        endcase
                    end
                end
                S_WAIT: begin
                    if (tgt_err_i) begin
                        st     <= S_FAIL;
                        r_size <= 1'b0;
                    end else if (tgt_done_i) begin
                        st <= S_BEAT;
                    end
                end
                S_BEAT: begin
                    if (cnt == '0) st <= S_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        aack_o      = (st == S_ACK) || (st == S_FAIL) || ((st == S_BEAT) && (cnt == '0));
        ta_o        = ((st == S_ACK) && r_ta) || (st == S_BEAT);
        tea_o       = (st == S_FAIL);
        ones_o      = r_ones && ta_o;
        tgt_req_o   = (st == S_WAIT);
        tgt_rd_o    = (st == S_WAIT) && r_rd;
        fail_ev_o   = (st == S_FAIL);
        fail_size_o = r_size;
        fail_addr_o = r_addr;
    end

endmodule

// File: rtl/cbt_errlog.sv
module cbt_errlog #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fail_ev_i,
    input  logic          fail_size_i,
    input  logic [AW-1:0] fail_addr_i,
    input  logic          clr_i,
    output logic          size_err_o,
    output logic          tgt_err_o,
    output logic [AW-1:0] err_addr_o
);

    logic any_held;

    assign any_held = size_err_o || tgt_err_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            size_err_o <= 1'b0;
            tgt_err_o  <= 1'b0;
            err_addr_o <= '0;
        end else begin
            if (clr_i) begin
                size_err_o <= 1'b0;
                tgt_err_o  <= 1'b0;
            end
            if (fail_ev_i) begin
                if (fail_size_i) size_err_o <= 1'b1;
                else             tgt_err_o  <= 1'b1;
                if (!any_held || clr_i) err_addr_o <= fail_addr_i;
            end
        end
    end

endmodule

// File: rtl/cbt_term.sv
module cbt_term
    import cbt_pkg::*;
#(
    parameter int AW          = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ts_i,
    input  logic [3:0]    tt_i,
    input  logic [2:0]    tsiz_i,
    input  logic          burst_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] tom_i,
    input  logic          tgt_done_i,
    input  logic          tgt_err_i,
    input  logic          err_clr_i,
    output logic          aack_o,
    output logic          ta_o,
    output logic          tea_o,
    output logic          ones_o,
    output logic          tgt_req_o,
    output logic          tgt_rd_o,
    output logic          size_err_o,
    output logic          tgt_err_o,
    output logic [AW-1:0] err_addr_o
);

    dec_t          dec;
    logic          fail_ev;
    logic          fail_size;
    logic [AW-1:0] fail_addr;

    cbt_decode #(.AW(AW)) u_dec (
        .tt_i    (tt_i),
        .tsiz_i  (tsiz_i),
        .burst_i (burst_i),
        .addr_i  (addr_i),
        .tom_i   (tom_i),
        .dec_o   (dec)
    );

    cbt_seq #(.AW(AW), .BURST_BEATS(BURST_BEATS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ts_i        (ts_i),
        .dec_i       (dec),
        .addr_i      (addr_i),
        .tgt_done_i  (tgt_done_i),
        .tgt_err_i   (tgt_err_i),
        .aack_o      (aack_o),
        .ta_o        (ta_o),
        .tea_o       (tea_o),
        .ones_o      (ones_o),
        .tgt_req_o   (tgt_req_o),
        .tgt_rd_o    (tgt_rd_o),
        .fail_ev_o   (fail_ev),
        .fail_size_o (fail_size),
        .fail_addr_o (fail_addr)
    );

    cbt_errlog #(.AW(AW)) u_err (
        .clk         (clk),
        .rst         (rst),
        .fail_ev_i   (fail_ev),
        .fail_size_i (fail_size),
        .fail_addr_i (fail_addr),
        .clr_i       (err_clr_i),
        .size_err_o  (size_err_o),
        .tgt_err_o   (tgt_err_o),
        .err_addr_o  (err_addr_o)
    );

endmodule

// File: rtl/cbt_term_chk.sv
module cbt_term_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          aack_o,
    input logic          ta_o,
    input logic          tea_o,
    input logic          ones_o,
    input logic          tgt_req_o,
    input logic          tgt_done_i,
    input logic          tgt_err_i,
    input logic          err_clr_i,
    input logic          size_err_o,
    input logic          tgt_err_o,
    input logic [AW-1:0] err_addr_o
);

    assert_tea_with_aack_R4: assert property (@(posedge clk) disable iff (rst)
        tea_o |-> aack_o);

    assert_ta_tea_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(ta_o && tea_o));

    assert_idle_after_aack_R8: assert property (@(posedge clk) disable iff (rst)
        aack_o |=> (!ta_o && !tea_o && !aack_o));

    assert_no_ack_while_req_R8: assert property (@(posedge clk) disable iff (rst)
        tgt_req_o |-> (!aack_o && !ta_o));

    assert_ones_on_beat_R2: assert property (@(posedge clk) disable iff (rst)
        ones_o |-> ta_o);

    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        (tgt_req_o && !tgt_done_i && !tgt_err_i) |=> tgt_req_o);

    assert_size_flag_src_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(size_err_o) |-> $past(tea_o));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(size_err_o) || $fell(tgt_err_o)) |-> $past(err_clr_i));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(size_err_o || tgt_err_o) && !$past(err_clr_i)) |-> $stable(err_addr_o));

endmodule

bind cbt_term cbt_term_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .aack_o     (aack_o),
    .ta_o       (ta_o),
    .tea_o      (tea_o),
    .ones_o     (ones_o),
    .tgt_req_o  (tgt_req_o),
    .tgt_done_i (tgt_done_i),
    .tgt_err_i  (tgt_err_i),
    .err_clr_i  (err_clr_i),
    .size_err_o (size_err_o),
    .tgt_err_o  (tgt_err_o),
    .err_addr_o (err_addr_o)
);

// File: tb/tb_cbt_term.sv
module tb_cbt_term;

    localparam logic [31:0] TOM = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ts_i = 1'b0;
    logic [3:0]  tt_i = '0;
    logic [2:0]  tsiz_i = '0;
    logic        burst_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [31:0] tom_i = TOM;
    logic        tgt_done_i = 1'b0;
    logic        tgt_err_i = 1'b0;
    logic        err_clr_i = 1'b0;
    logic        aack_o, ta_o, tea_o, ones_o, tgt_req_o, tgt_rd_o;
    logic        size_err_o, tgt_err_o;
    logic [31:0] err_addr_o;

    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          m_sz = 0;
    bit          m_te = 0;
    logic [31:0] m_ea = '0;

    always #10 clk = ~clk;

    cbt_term dut (
        .clk(clk), .rst(rst), .ts_i(ts_i), .tt_i(tt_i), .tsiz_i(tsiz_i),
        .burst_i(burst_i), .addr_i(addr_i), .tom_i(tom_i),
        .tgt_done_i(tgt_done_i), .tgt_err_i(tgt_err_i), .err_clr_i(err_clr_i),
        .aack_o(aack_o), .ta_o(ta_o), .tea_o(tea_o), .ones_o(ones_o),
        .tgt_req_o(tgt_req_o), .tgt_rd_o(tgt_rd_o), .size_err_o(size_err_o),
        .tgt_err_o(tgt_err_o), .err_addr_o(err_addr_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    // Compare all outputs against the model at the current negedge
    task automatic cmp(input string tag, input bit ea, input bit et, input bit ee,
                       input bit eo, input bit er, input bit erd);
        logic [5:0] act;
        logic [5:0] exp;
        act = {aack_o, ta_o, tea_o, ones_o, tgt_req_o, tgt_rd_o};
        exp = {ea, et, ee, eo, er, erd};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s strobes{aack,ta,tea,ones,req,rd} act=%b exp=%b t=%0t",
                     tag, act, exp, $time);
        end
        n_chk++;
        if ({size_err_o, tgt_err_o} !== {m_sz, m_te} || err_addr_o !== m_ea) begin
            n_fail++;
            $display("FAIL %s flags{sz,te,addr} act=%b%b %h exp=%b%b %h t=%0t",
                     tag, size_err_o, tgt_err_o, err_addr_o, m_sz, m_te, m_ea, $time);
        end
    endtask

    task automatic note_err(input bit is_size, input logic [31:0] a);
        if (!m_sz && !m_te) m_ea = a;
        if (is_size) m_sz = 1;
        else         m_te = 1;
    endtask

    task automatic txn(input logic [3:0] code, input logic [2:0] tsz, input bit bst,
                       input logic [31:0] a, input int lat, input bit terr,
                       input bit poke, input string tag);
        bit special;
        bit aonly;
        bit rd;
        bit legal;
        bit hole;
        int bytes;
        int beats;
        special = (code == 4'hA) || (code == 4'hE);
        aonly   = !special && (code % 2 == 0);
        rd      = ((code / 4) % 2) == 1;
        bytes   = (tsz == 3'd0) ? 8 : int'(tsz);
        if (bst) legal = (a % 8 == 0);
        else     legal = (tsz <= 3'd4) && ((a % 8) + bytes <= 8);
        hole    = (a >= TOM);
        beats   = bst ? 4 : 1;

        @(negedge clk);
        ts_i = 1'b1; tt_i = code; tsiz_i = tsz; burst_i = bst; addr_i = a;
        @(negedge clk);
        ts_i = 1'b0;
        if (special || aonly) begin
            cmp(tag, 1, special, 0, code == 4'hE, 0, 0);
        end else if (!legal) begin
            cmp(tag, 1, 0, 1, 0, 0, 0);
            note_err(1, a);
        end else begin
            if (!hole) begin
                for (int w = 0; w <= lat; w++) begin
                    if (poke && w == 0) begin
                        ts_i = 1'b1; tt_i = 4'hE;
                    end
                    cmp(tag, 0, 0, 0, 0, 1, rd);
                    if (w == lat) begin
                        if (terr) tgt_err_i = 1'b1;
                        else      tgt_done_i = 1'b1;
                    end
                    @(negedge clk);
                end
                tgt_done_i = 1'b0; tgt_err_i = 1'b0; ts_i = 1'b0;
            end
            if (!hole && terr) begin
                cmp(tag, 1, 0, 1, 0, 0, 0);
                note_err(0, a);
            end else begin
                for (int b = 0; b < beats; b++) begin
                    cmp(tag, b == beats - 1, 1, 0, hole && rd, 0, 0);
                    if (b < beats - 1) @(negedge clk);
                end
            end
        end
        @(negedge clk);
        cmp({tag, "_idle_R8"}, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic clear_flags;
        @(negedge clk);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        m_sz = 0; m_te = 0;
        cmp("R9_clear", 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp("R10_reset", 0, 0, 0, 0, 0, 0);

        // every transfer-type code, single and burst: R1 R2 R3 R5
        for (int c = 0; c < 16; c++) begin
            txn(4'(c), 3'd0, 0, 32'h0000_0100, 1, 0, 0, "R1_R2_R3_code");
            txn(4'(c), 3'd0, 1, 32'h0000_0200, 0, 0, 0, "R1_R2_R5_code_burst");
        end
        // address-only and special ignore size/alignment: R1 R2
        txn(4'h4, 3'd7, 0, 32'h0000_0003, 0, 0, 0, "R1_badsize");
        txn(4'hE, 3'd6, 1, 32'h0000_0005, 0, 0, 0, "R2_badsize");

        // full size x offset sweep: R4 R5
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 8; s++)
                for (int o = 0; o < 8; o++)
                    txn((o % 2 == 0) ? 4'h5 : 4'h1, 3'(s), b[0],
                        32'h0000_0400 + 32'(o), o % 3, 0, 0, "R4_R5_sweep");
        clear_flags();

        // top-of-memory boundary: R6
        txn(4'h5, 3'd0, 0, TOM - 32'd8, 0, 0, 0, "R6_below_top");
        txn(4'h5, 3'd0, 0, TOM, 0, 0, 0, "R6_at_top_read");
        txn(4'h1, 3'd4, 0, TOM, 0, 0, 0, "R6_at_top_write");
        txn(4'hD, 3'd0, 1, 32'h2000_0000, 0, 0, 0, "R6_burst_read");
        txn(4'h9, 3'd0, 1, 32'h2000_0008, 0, 0, 0, "R6_burst_write");
        txn(4'h7, 3'd7, 0, 32'h2000_0000, 0, 0, 0, "R6_R4_illegal_hole");
        clear_flags();

        // target error, first-error address, clear: R7 R9
        txn(4'h5, 3'd4, 0, 32'h0000_0800, 2, 1, 0, "R7_tgt_err");
        txn(4'h1, 3'd4, 0, 32'h0000_0805, 0, 0, 0, "R9_second_err");
        txn(4'hF, 3'd0, 1, 32'h0000_0900, 4, 1, 0, "R7_R9_burst_err");
        clear_flags();
        txn(4'h3, 3'd2, 0, 32'h0000_0A06, 0, 0, 0, "R9_after_clear");
        txn(4'h1, 3'd2, 0, 32'h0000_0A07, 0, 0, 0, "R4_R9_cross");
        clear_flags();

        // transfer start during a busy transaction is ignored: R8
        txn(4'h1, 3'd0, 1, 32'h0000_0040, 3, 0, 1, "R8_poke_burst");
        txn(4'h5, 3'd1, 0, 32'h0000_0047, 2, 0, 1, "R8_poke_single");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule